// File: doc/BRIEF.md
# Three-Mode Microprocessor Bus Front End

This block connects an external 8-bit microprocessor to the register and memory space of a larger device. A static mode input selects one of three bus styles, and the same five control pins change meaning with that choice:

- **Direct mode.** A separate address comes in on dedicated pins, with an active-high data strobe and a read/write direction pin.
- **Strobe-and-direction multiplexed mode.** The address shares the data lines with the data and is captured by an address strobe. The data strobe and direction pin work as in direct mode.
- **Separate read/write multiplexed mode.** The address is also captured from the data lines, but the strobe pin becomes an active-low read and the direction pin becomes an active-low write.

All bus pins are asynchronous to the device clock. They are brought into the clock domain through a synchronizer before anything is decoded. The block produces four things:

- a request address;
- a read enable that also drives the data-bus output enable;
- a single-cycle write pulse;
- the write data that belongs to that pulse.

Read data from the addressed location goes out on the data lines only while a read is active.

In direct mode, some of the upper address pins share a package pin with serial outputs. How many of the upper pins actually carry address depends on a rate setting, and the bits that do not carry address read as zero.

Top module: `mpu_bus_if`

## Requirements
- R1: During reset and right after it, `bus_oe_o`, `wr_pulse_o`, `req_addr_o`, `wr_data_o` and `bus_out_o` are all zero.
- R2: While `cs_n_i` is high, no read enable and no write pulse are produced, whatever the strobe and direction pins do.
- R3: Read in modes 0 (direct) and 1 (strobe-and-direction multiplexed). When `cs_n_i`=0, `strb_i`=1 and `dir_i`=1 are all true, `bus_oe_o` goes high and `bus_out_o` equals `rd_data_i`. This appears three clock edges after the pins change, and the same latency applies to every pin-to-output path.
- R4: Write in modes 0 and 1. When `cs_n_i`=0, `strb_i`=1 and `dir_i`=0 are all true, that condition is the write qualifier. When the qualifier ends, `wr_data_o` holds the data-line value from the last cycle in which the qualifier was true.
- R5: Read in mode 2 (separate read/write multiplexed). A read happens when `cs_n_i`=0, `strb_i`=0 (read asserted) and `dir_i`=1 (write not asserted).
- R6: Write in mode 2. The write qualifier is `cs_n_i`=0, `dir_i`=0 (write asserted) and `strb_i`=1 (read not asserted). Its end produces the write pulse, with the data taken as in R4.
- R7: In modes 1 and 2, the data-line value is captured into the address latch when `as_i` falls. `req_addr_o` then shows that value until the next falling edge, even while the data lines carry data.
- R8: In mode 0, `req_addr_o` is {upper, `addr_lo_i`}. Upper bit i comes from `addr_hi_i`[i] when `rate_i` > i; otherwise it reads as zero.
- R9: Whenever `bus_oe_o` is low, `bus_out_o` is zero.
- R10: Mode 3 is reserved. In mode 3 no read enable and no write pulse are ever produced.
- R11: Each write access gives exactly one `wr_pulse_o` cycle, however long the qualifier is held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Device clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Static bus style: 0 direct, 1 strobe-and-direction multiplexed, 2 separate read/write multiplexed, 3 reserved |
| rate_i | input | RATE_W | Number of upper address pins that carry address in direct mode |
| cs_n_i | input | 1 | Chip select, active low |
| strb_i | input | 1 | Data strobe (active high) in modes 0 and 1; read (active low) in mode 2 |
| dir_i | input | 1 | Read high / write low in modes 0 and 1; write (active low) in mode 2 |
| as_i | input | 1 | Address strobe for the multiplexed modes; the latch captures on its falling edge |
| addr_lo_i | input | LO_W | Dedicated low address pins (direct mode) |
| addr_hi_i | input | HI_W | Upper address pins shared with serial outputs (direct mode) |
| bus_in_i | input | DATA_W | Input side of the bidirectional data lines |
| bus_out_o | output | DATA_W | Output side of the data lines |
| bus_oe_o | output | 1 | Data-line output enable, also the internal read enable |
| rd_data_i | input | DATA_W | Read data from the addressed location |
| req_addr_o | output | DATA_W | Request address |
| wr_pulse_o | output | 1 | One-cycle write request |
| wr_data_o | output | DATA_W | Write data belonging to the write pulse |

## Verification
A wrong internal state shows up at the ports within three to four clocks. A bad synchronizer or decode state shows up in two ways: `bus_oe_o` drives the data lines during a write or an unselected cycle, or it stays low during a read. A stuck qualifier history shows as a missing or repeated write pulse at the end of an access. A corrupted address latch shows on `req_addr_o` right after the falling address strobe, and it stays wrong for the whole access, so it can be seen even after the data lines have changed. Because the bench model tracks every pin through the same three-edge latency, any such fault shows as a mismatch in the first cycle it occurs.

// File: rtl/mpu_bus_if_pkg.sv
package mpu_bus_if_pkg;
   typedef enum logic [1:0] {
      MODE_DIRECT  = 2'd0,
      MODE_MUX_DS  = 2'd1,
      MODE_MUX_RW  = 2'd2,
      MODE_RSVD    = 2'd3
   } bus_mode_e;

   function automatic logic mode_is_mux(bus_mode_e m);
      return (m == MODE_MUX_DS) || (m == MODE_MUX_RW);
   endfunction
endpackage

// File: rtl/mbi_sync.sv
module mbi_sync #(
   parameter int            W       = 8,
   parameter int            STAGES  = 2,
   parameter logic [W-1:0]  RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [STAGES-1:0][W-1:0] stg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
      end else begin
         stg[0] <= d;
         for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/mbi_decode.sv
module mbi_decode
   import mpu_bus_if_pkg::*;
(
   input  bus_mode_e mode,
   input  logic      cs_n,
   input  logic      strb,
   input  logic      dir,
   output logic      rd_q,
   output logic      wr_q
);
   always_comb begin
      rd_q = 1'b0;
      wr_q = 1'b0;
      if (!cs_n) begin
         case (mode)
            MODE_DIRECT, MODE_MUX_DS: begin
               rd_q = strb & dir;
               wr_q = strb & ~dir;
            end
            MODE_MUX_RW: begin
               rd_q = ~strb & dir;
               wr_q = ~dir & strb;
            end
            default: begin
               rd_q = 1'b0;
               wr_q = 1'b0;
            end
         endcase
      end
   end
endmodule

// File: rtl/mbi_addr.sv
module mbi_addr #(
   parameter int DATA_W = 8,
   parameter int LO_W   = 6,
   parameter int HI_W   = 2,
   parameter int RATE_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mux_sel,
   input  logic              as,
   input  logic [DATA_W-1:0] bus,
   input  logic [LO_W-1:0]   lo,
   input  logic [HI_W-1:0]   hi,
   input  logic [RATE_W-1:0] rate,
   output logic [DATA_W-1:0] addr
);
   logic              as_prev;
   logic [DATA_W-1:0] latch_r;
   logic [DATA_W-1:0] direct_r;
   logic [HI_W-1:0]   hi_en;

   generate
      for (genvar i = 0; i < HI_W; i++) begin : g_hi_en
         assign hi_en[i] = (int'(rate) > i);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         as_prev  <= 1'b0;
         latch_r  <= '0;
         direct_r <= '0;
      end else begin
         as_prev  <= as;
         if (mux_sel && as_prev && !as) latch_r <= bus;
         direct_r <= {hi & hi_en, lo};
      end
   end

   assign addr = mux_sel ? latch_r : direct_r;
endmodule

// File: rtl/mpu_bus_if.sv
module mpu_bus_if
   import mpu_bus_if_pkg::*;
#(
   parameter  int DATA_W      = 8,
   parameter  int LO_W        = 6,
   parameter  int HI_W        = 2,
   parameter  int SYNC_STAGES = 2,
   localparam int RATE_W      = $clog2(HI_W + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        mode_i,
   input  logic [RATE_W-1:0] rate_i,
   input  logic              cs_n_i,
   input  logic              strb_i,
   input  logic              dir_i,
   input  logic              as_i,
   input  logic [LO_W-1:0]   addr_lo_i,
   input  logic [HI_W-1:0]   addr_hi_i,
   input  logic [DATA_W-1:0] bus_in_i,
   output logic [DATA_W-1:0] bus_out_o,
   output logic              bus_oe_o,
   input  logic [DATA_W-1:0] rd_data_i,
   output logic [DATA_W-1:0] req_addr_o,
   output logic              wr_pulse_o,
   output logic [DATA_W-1:0] wr_data_o
);
   localparam int SW = 4 + DATA_W + LO_W + HI_W;
   localparam logic [SW-1:0] SYNC_RST = SW'(1) << (SW - 1);

   generate
      if (LO_W + HI_W != DATA_W) begin : g_bad_addr
         $error("mpu_bus_if: LO_W + HI_W must equal DATA_W");
      end
      if (SYNC_STAGES < 2 || SYNC_STAGES > 3) begin : g_bad_sync
         $error("mpu_bus_if: SYNC_STAGES must be 2 or 3");
      end
      if (HI_W < 1 || LO_W < 1) begin : g_bad_split
         $error("mpu_bus_if: address split needs at least one bit on each side");
      end
   endgenerate

   bus_mode_e         mode;
   logic              s_cs_n, s_strb, s_dir, s_as;
   logic [DATA_W-1:0] s_bus;
   logic [LO_W-1:0]   s_lo;
   logic [HI_W-1:0]   s_hi;
   logic              rd_q, wr_q;
   logic              oe_r, wrq_r, pulse_r;
   logic [DATA_W-1:0] wdata_r;

   assign mode = bus_mode_e'(mode_i);

   mbi_sync #(.W(SW), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({cs_n_i, strb_i, dir_i, as_i, bus_in_i, addr_lo_i, addr_hi_i}),
      .q     ({s_cs_n, s_strb, s_dir, s_as, s_bus, s_lo, s_hi})
   );

   mbi_decode u_dec (
      .mode (mode),
      .cs_n (s_cs_n),
      .strb (s_strb),
      .dir  (s_dir),
      .rd_q (rd_q),
      .wr_q (wr_q)
   );

   mbi_addr #(.DATA_W(DATA_W), .LO_W(LO_W), .HI_W(HI_W), .RATE_W(RATE_W)) u_addr (
      .clk     (clk),
      .rst_n   (rst_n),
      .mux_sel (mode_is_mux(mode)),
      .as      (s_as),
      .bus     (s_bus),
      .lo      (s_lo),
      .hi      (s_hi),
      .rate    (rate_i),
      .addr    (req_addr_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         oe_r    <= 1'b0;
         wrq_r   <= 1'b0;
         pulse_r <= 1'b0;
         wdata_r <= '0;
      end else begin
         oe_r    <= rd_q;
         wrq_r   <= wr_q;
         pulse_r <= wrq_r & ~wr_q;
         if (wr_q) wdata_r <= s_bus;
      end
   end

   assign bus_oe_o   = oe_r;
   assign bus_out_o  = oe_r ? rd_data_i : '0;
   assign wr_pulse_o = pulse_r;
   assign wr_data_o  = wdata_r;
endmodule

// File: rtl/mpu_bus_if_chk.sv
module mpu_bus_if_chk #(
   parameter int DATA_W = 8,
   parameter int LAT    = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cs_n_i,
   input logic              bus_oe_o,
   input logic [DATA_W-1:0] bus_out_o,
   input logic              wr_pulse_o
);
   logic [2:0] cyc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         cyc <= '0;
      else if (cyc != '1) cyc <= cyc + 3'd1;
   end

   // R2
   no_read_unselected_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(cyc) > LAT && $past(cs_n_i, LAT)) |-> !bus_oe_o);

   // R9
   bus_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_oe_o |-> (bus_out_o == '0));

   // R11
   single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_pulse_o |=> !wr_pulse_o);

   // R1
   reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc == 3'd0) |-> (!bus_oe_o && !wr_pulse_o));
endmodule

bind mpu_bus_if mpu_bus_if_chk #(.DATA_W(DATA_W), .LAT(SYNC_STAGES + 1)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cs_n_i     (cs_n_i),
   .bus_oe_o   (bus_oe_o),
   .bus_out_o  (bus_out_o),
   .wr_pulse_o (wr_pulse_o)
);

// File: tb/mpu_bus_if_test.sv
module mpu_bus_if_test;
   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic       rst_n = 1'b0;
   logic [1:0] mode = 2'd0;
   logic [1:0] rate = 2'd2;
   logic       cs_n = 1'b1, strb = 1'b0, dir = 1'b0, as = 1'b0;
   logic [5:0] lo = '0;
   logic [1:0] hi = '0;
   logic [7:0] bus_in = '0, rd_data = '0;
   logic [7:0] bus_out, req_addr, wr_data;
   logic       bus_oe, wr_pulse;

   mpu_bus_if uut (
      .clk(clk), .rst_n(rst_n), .mode_i(mode), .rate_i(rate),
      .cs_n_i(cs_n), .strb_i(strb), .dir_i(dir), .as_i(as),
      .addr_lo_i(lo), .addr_hi_i(hi), .bus_in_i(bus_in),
      .bus_out_o(bus_out), .bus_oe_o(bus_oe), .rd_data_i(rd_data),
      .req_addr_o(req_addr), .wr_pulse_o(wr_pulse), .wr_data_o(wr_data)
   );

   typedef struct packed {
      logic       cs_n, strb, dir, as;
      logic [7:0] bus;
      logic [5:0] lo;
      logic [1:0] hi;
   } ent_t;

   int    n_total = 0, n_fail = 0, pulse_cnt = 0, oe_cnt = 0;
   string ph = "R1";
   bit    done = 0;

   ent_t       hist[$];
   logic [7:0] m_latch, m_wdata, e_addr;
   logic       e_oe, e_pulse;

   function automatic bit f_rd(ent_t e, logic [1:0] m);
      if (e.cs_n) return 1'b0;
      case (m)
         2'd0, 2'd1: return e.strb & e.dir;
         2'd2:       return !e.strb & e.dir;
         default:    return 1'b0;
      endcase
   endfunction

   function automatic bit f_wr(ent_t e, logic [1:0] m);
      if (e.cs_n) return 1'b0;
      case (m)
         2'd0, 2'd1: return e.strb & !e.dir;
         2'd2:       return !e.dir & e.strb;
         default:    return 1'b0;
      endcase
   endfunction

   function automatic logic [7:0] f_comp(ent_t e, logic [1:0] r);
      logic [1:0] h = e.hi;
      if (r < 2) h[1] = 1'b0;
      if (r < 1) h[0] = 1'b0;
      return {h, e.lo};
   endfunction

   task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
      n_total++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // reference model, compared on every clock
   always @(posedge clk) begin
      ent_t idle, cur;
      bit   mux;
      idle = '0; idle.cs_n = 1'b1;
      if (!rst_n) begin
         hist = '{idle, idle, idle, idle};
         m_latch = '0; m_wdata = '0; e_oe = 0; e_pulse = 0; e_addr = '0;
      end else begin
         cur = '{cs_n: cs_n, strb: strb, dir: dir, as: as, bus: bus_in, lo: lo, hi: hi};
         hist.push_front(cur);
         void'(hist.pop_back());
         mux = (mode == 2'd1) || (mode == 2'd2);
         if (mux && hist[3].as && !hist[2].as) m_latch = hist[2].bus;
         if (f_wr(hist[2], mode)) m_wdata = hist[2].bus;
         e_oe    = f_rd(hist[2], mode);
         e_pulse = f_wr(hist[3], mode) && !f_wr(hist[2], mode);
         e_addr  = mux ? m_latch : f_comp(hist[2], rate);
         #1;
         if (wr_pulse) pulse_cnt++;
         if (bus_oe)   oe_cnt++;
         check(bus_oe == e_oe && wr_pulse == e_pulse && req_addr == e_addr &&
               wr_data == m_wdata && bus_out == (e_oe ? rd_data : 8'h00),
               ph, "oe/pulse/addr/wdata/out",
               {bus_oe, wr_pulse, req_addr, wr_data, bus_out[5:0]},
               {e_oe, e_pulse, e_addr, m_wdata, (e_oe ? rd_data[5:0] : 6'h00)});
      end
   end

   task automatic step(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("%0d/%0d checks passed", n_total - n_fail, n_total);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_total++; n_fail++;
      $display("FAIL watchdog run did not finish actual=hung expected=done");
      finish_run();
   end

   initial begin
      step(4);
      check(bus_oe == 0 && wr_pulse == 0 && req_addr == 0 && wr_data == 0 && bus_out == 0,
            "R1", "outputs in reset", {bus_oe, wr_pulse, req_addr}, 0);
      rst_n = 1'b1;
      step(1);
      check(bus_oe == 0 && wr_pulse == 0 && req_addr == 0, "R1", "outputs after reset",
            {bus_oe, wr_pulse, req_addr}, 0);

      // direct-mode read
      ph = "R3";
      lo = 6'h15; hi = 2'b11; rd_data = 8'hA5;
      cs_n = 0; dir = 1; strb = 1;
      step(5);
      check(bus_oe && bus_out == 8'hA5, "R3", "direct read data", bus_out, 8'hA5);
      check(req_addr == 8'hD5, "R8", "direct address full rate", req_addr, 8'hD5);
      rd_data = 8'h3E; step(1);
      check(bus_out == 8'h3E, "R3", "read data follows source", bus_out, 8'h3E);
      cs_n = 1; strb = 0;
      ph = "R9"; step(5);
      check(!bus_oe && bus_out == 0, "R9", "bus released", bus_out, 0);

      // direct-mode write, long qualifier
      ph = "R4"; pulse_cnt = 0;
      dir = 0; cs_n = 0; bus_in = 8'h11; step(1);
      strb = 1; bus_in = 8'h22; step(1);
      bus_in = 8'h3C; step(6);
      strb = 0; bus_in = 8'hFF; step(6);
      check(pulse_cnt == 1, "R11", "one pulse per long write", pulse_cnt, 1);
      check(wr_data == 8'h3C, "R4", "write data last qualified", wr_data, 8'h3C);
      cs_n = 1;

      // rate-dependent upper address
      ph = "R8";
      rate = 2'd0; step(5);
      check(req_addr == 8'h15, "R8", "rate 0 upper zero", req_addr, 8'h15);
      rate = 2'd1; step(5);
      check(req_addr == 8'h55, "R8", "rate 1 one upper bit", req_addr, 8'h55);
      rate = 2'd2;

      // chip select high blocks everything
      ph = "R2"; pulse_cnt = 0; oe_cnt = 0;
      strb = 1; dir = 1; step(4);
      dir = 0; step(4);
      strb = 0; step(5);
      check(pulse_cnt == 0 && oe_cnt == 0, "R2", "no access unselected", {pulse_cnt, oe_cnt}, 0);

      // strobe-and-direction multiplexed
      mode = 2'd1; ph = "R7"; step(4);
      as = 1; bus_in = 8'h9E; step(2);
      as = 0; step(2);
      bus_in = 8'h00; lo = '0; hi = '0; step(3);
      check(req_addr == 8'h9E, "R7", "latched address mode 1", req_addr, 8'h9E);
      ph = "R3"; rd_data = 8'h5A;
      cs_n = 0; dir = 1; strb = 1; step(5);
      check(bus_oe && bus_out == 8'h5A, "R3", "mode 1 read", bus_out, 8'h5A);
      check(req_addr == 8'h9E, "R7", "latch held through data", req_addr, 8'h9E);
      strb = 0; cs_n = 1; step(5);
      ph = "R4"; pulse_cnt = 0;
      dir = 0; cs_n = 0; bus_in = 8'h77; strb = 1; step(4);
      strb = 0; step(5);
      check(pulse_cnt == 1 && wr_data == 8'h77, "R4", "mode 1 write", wr_data, 8'h77);
      cs_n = 1;

      // separate read/write multiplexed
      strb = 1; dir = 1; step(2);
      mode = 2'd2; step(5);
      ph = "R7";
      as = 1; bus_in = 8'h3B; step(2);
      as = 0; step(2);
      bus_in = 8'h00; step(3);
      check(req_addr == 8'h3B, "R7", "latched address mode 2", req_addr, 8'h3B);
      ph = "R5"; rd_data = 8'hC3;
      cs_n = 0; strb = 0; step(5);
      check(bus_oe && bus_out == 8'hC3, "R5", "mode 2 read", bus_out, 8'hC3);
      strb = 1; step(5);
      check(!bus_oe, "R5", "mode 2 read ends", bus_oe, 0);
      ph = "R6"; pulse_cnt = 0;
      bus_in = 8'h6D; dir = 0; step(6);
      dir = 1; bus_in = 8'h00; step(5);
      check(pulse_cnt == 1 && wr_data == 8'h6D, "R6", "mode 2 write", wr_data, 8'h6D);
      check(pulse_cnt == 1, "R11", "mode 2 single pulse", pulse_cnt, 1);
      cs_n = 1; step(4);

      // reserved mode
      mode = 2'd3; ph = "R10"; step(4);
      pulse_cnt = 0; oe_cnt = 0;
      cs_n = 0; strb = 1; dir = 1; step(4);
      strb = 0; step(4);
      dir = 0; step(4);
      strb = 1; step(4);
      dir = 1; step(4);
      cs_n = 1; step(4);
      check(pulse_cnt == 0 && oe_cnt == 0, "R10", "reserved mode no access", {pulse_cnt, oe_cnt}, 0);

      finish_run();
   end
endmodule